// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This block sits beside a single-precision (32-bit) two-operand arithmetic datapath. It computes the result of an operation when at least one operand is a NaN. Each operand is classified as a quiet or a signaling NaN. One of the two is chosen by a policy that a static mode input selects, and the chosen operand is made quiet. When default-NaN mode is on, a fixed default NaN is returned in its place.

A signaling operand sets a sticky invalid-operation flag. The flag stays set until a synchronous clear. The result is registered and is presented one cycle after the input strobe. A polarity control changes the meaning of the quiet bit, which is the most significant fraction bit, bit 22. Arithmetic on operands that are not NaNs is outside this block.

Top module: `nan_prop_unit`

## Requirements
- R1: With `sig_inv_i`=0, an operand is quiet when bits 30:23 are all ones and bit 22 is 1. It is signaling when bits 30:23 are all ones, bit 22 is 0 and bits 21:0 are not zero.
- R2: With `sig_inv_i`=1, the quiet and signaling tests of R1 trade places. An operand with bit 22 clear and a nonzero fraction is quiet. An operand with all-ones exponent and bit 22 set is signaling.
- R3: When the chosen operand is signaling, it is quieted before output. With `sig_inv_i`=0 this sets bit 22. With `sig_inv_i`=1 the result is 0x7FBFFFFF. A chosen operand that is not signaling passes through unchanged.
- R4: With `dflt_nan_i`=1 the result is 0x7FC00000 when `sig_inv_i`=0 and 0x7FBFFFFF when `sig_inv_i`=1, whatever the operands are.
- R5: `mode_i`=0 (signaling first) chooses in this order: A if signaling, then B if signaling, then A if quiet, otherwise B.
- R6: `mode_i`=1 (first operand) chooses A if A is any NaN, otherwise B.
- R7: `mode_i`=2 (magnitude) follows these rules. A signaling NaN paired with a quiet NaN yields the quiet one. Two NaNs of the same kind yield the one of larger magnitude. A lone NaN is returned.
- R8: In `mode_i`=2, magnitude compares bits 30:0 of the two operands. On a tie, A counts as larger only when its raw unsigned value is below B's.
- R9: `mode_i`=3 behaves exactly as `mode_i`=0.
- R10: `res_valid_o` is high in the cycle after each `in_valid_i` cycle and low otherwise. `res_o` changes only after an accepted operation.
- R11: An accepted operation with a signaling operand sets `invalid_o`, also under default-NaN mode. Once set, `invalid_o` stays set until a clear.
- R12: `clr_invalid_i` clears `invalid_o` on the next edge. A set from the same cycle's operation takes priority over the clear.
- R13: After reset, `res_valid_o`, `res_o` and `invalid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| mode_i | input | 2 | Selection policy: 0 signaling first, 1 first operand, 2 magnitude, 3 same as 0 |
| sig_inv_i | input | 1 | Inverted quiet-bit polarity |
| dflt_nan_i | input | 1 | Return the default NaN |
| clr_invalid_i | input | 1 | Synchronous clear of the sticky flag |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 32 | Result NaN |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
The hardest case to reach is the tie in the magnitude policy. Both operands must be NaNs of the same kind with identical bits 30:0, and they may differ only in sign. The stimulus drives such pairs in both sign orders, so that the raw-value tie-break is the only thing that decides the outcome. The stimulus also drives a signaling operand together with the clear input, which shows that the set takes priority.

// File: rtl/nan_prop_pkg.sv
package nan_prop_pkg;
  localparam int unsigned FP_W   = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = FP_W - EXP_W - 1;
  localparam int unsigned QBIT   = MAN_W - 1;
  localparam int unsigned MAG_W  = FP_W - 1;

  localparam logic [FP_W-1:0] DNAN_STD = 32'h7FC0_0000;
  localparam logic [FP_W-1:0] DNAN_INV = 32'h7FBF_FFFF;

  typedef enum logic [1:0] {
    SEL_SIG_FIRST = 2'd0,
    SEL_A_FIRST   = 2'd1,
    SEL_MAG       = 2'd2,
    SEL_RSVD      = 2'd3
  } sel_mode_e;

  typedef struct packed {
    logic is_q;
    logic is_s;
  } nan_cls_t;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_prop_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  input  logic            inv_i,
  output nan_cls_t        cls_o
);
  logic exp_ones, qbit, low_nz, hi_nan, lo_nan;

  assign exp_ones = &val_i[FP_W-2 -: EXP_W];
  assign qbit     = val_i[QBIT];
  assign low_nz   = |val_i[QBIT-1:0];
  assign hi_nan   = exp_ones & qbit;
  assign lo_nan   = exp_ones & ~qbit & low_nz;

  always_comb begin
    cls_o.is_q = inv_i ? lo_nan : hi_nan;
    cls_o.is_s = inv_i ? hi_nan : lo_nan;
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_prop_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  nan_cls_t        ca_i,
  input  nan_cls_t        cb_i,
  input  logic [1:0]      mode_i,
  output logic            pick_b_o
);
  logic [MAG_W-1:0] mag_a, mag_b;
  logic a_larger, pick_sig, pick_first, pick_mag;

  assign mag_a = a_i[MAG_W-1:0];
  assign mag_b = b_i[MAG_W-1:0];

  // tie: A wins only if positive against negative
  always_comb begin
    if (mag_a > mag_b)      a_larger = 1'b1;
    else if (mag_a < mag_b) a_larger = 1'b0;
    else                    a_larger = (a_i < b_i);
  end

  always_comb begin
    if (ca_i.is_s)      pick_sig = 1'b0;
    else if (cb_i.is_s) pick_sig = 1'b1;
    else if (ca_i.is_q) pick_sig = 1'b0;
    else                pick_sig = 1'b1;
  end

  assign pick_first = ~(ca_i.is_s | ca_i.is_q);

  always_comb begin
    if (ca_i.is_s) begin
      if (cb_i.is_s)      pick_mag = ~a_larger;
      else                pick_mag = cb_i.is_q;
    end else if (ca_i.is_q) begin
      if (cb_i.is_s || !cb_i.is_q) pick_mag = 1'b0;
      else                         pick_mag = ~a_larger;
    end else begin
      pick_mag = 1'b1;
    end
  end

  always_comb begin
    unique case (sel_mode_e'(mode_i))
      SEL_A_FIRST: pick_b_o = pick_first;
      SEL_MAG:     pick_b_o = pick_mag;
      default:     pick_b_o = pick_sig;
    endcase
  end
endmodule

// File: rtl/nan_quiet.sv
module nan_quiet
  import nan_prop_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  input  logic            is_s_i,
  input  logic            inv_i,
  input  logic            dflt_i,
  output logic [FP_W-1:0] val_o
);
  logic [FP_W-1:0] dnan, set_q;

  assign dnan  = inv_i ? DNAN_INV : DNAN_STD;
  assign set_q = val_i | (FP_W'(1) << QBIT);

  always_comb begin
    if (dflt_i)      val_o = dnan;
    else if (!is_s_i) val_o = val_i;
    else if (inv_i)  val_o = DNAN_INV;
    else             val_o = set_q;
  end
endmodule

// File: rtl/nan_prop_unit.sv
module nan_prop_unit
  import nan_prop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [FP_W-1:0] opa_i,
  input  logic [FP_W-1:0] opb_i,
  input  logic [1:0]      mode_i,
  input  logic            sig_inv_i,
  input  logic            dflt_nan_i,
  input  logic            clr_invalid_i,
  output logic            res_valid_o,
  output logic [FP_W-1:0] res_o,
  output logic            invalid_o
);
  localparam int unsigned N_OPS = 2;

  logic [FP_W-1:0] ops [N_OPS];
  nan_cls_t        cls [N_OPS];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    nan_classify u_cls (
      .val_i (ops[g]),
      .inv_i (sig_inv_i),
      .cls_o (cls[g])
    );
  end

  logic            pick_b;
  logic [FP_W-1:0] sel_val, out_val;
  logic            sel_s, raise;

  nan_pick u_pick (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .ca_i     (cls[0]),
    .cb_i     (cls[1]),
    .mode_i   (mode_i),
    .pick_b_o (pick_b)
  );

  assign sel_val = pick_b ? opb_i : opa_i;
  assign sel_s   = pick_b ? cls[1].is_s : cls[0].is_s;

  nan_quiet u_quiet (
    .val_i  (sel_val),
    .is_s_i (sel_s),
    .inv_i  (sig_inv_i),
    .dflt_i (dflt_nan_i),
    .val_o  (out_val)
  );

  assign raise = in_valid_i & (cls[0].is_s | cls[1].is_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      invalid_o   <= 1'b0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) res_o <= out_val;
      if (raise)              invalid_o <= 1'b1;
      else if (clr_invalid_i) invalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nan_prop_unit_chk.sv
module nan_prop_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic        sig_inv_i,
  input logic        dflt_nan_i,
  input logic        clr_invalid_i,
  input logic        res_valid_o,
  input logic [31:0] res_o,
  input logic        invalid_o
);
  logic a_nan, b_nan, a_sn, b_sn;
  assign a_nan = (opa_i[30:23] == 8'hFF) && (opa_i[22:0] != 23'd0);
  assign b_nan = (opb_i[30:23] == 8'hFF) && (opb_i[22:0] != 23'd0);
  assign a_sn  = (opa_i[30:22] == 9'h1FE) && (opa_i[21:0] != 22'd0);
  assign b_sn  = (opb_i[30:22] == 9'h1FE) && (opb_i[21:0] != 22'd0);

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> res_valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!res_valid_o && $stable(res_o)));
  p_dflt_std_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dflt_nan_i && !sig_inv_i) |=> res_o == 32'h7FC0_0000);
  p_dflt_inv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dflt_nan_i && sig_inv_i) |=> res_o == 32'h7FBF_FFFF);
  p_quiet_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !dflt_nan_i && !sig_inv_i && (a_nan || b_nan))
      |=> res_o[30:22] == 9'h1FF);
  p_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sig_inv_i && (a_sn || b_sn)) |=> invalid_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !clr_invalid_i) |=> invalid_o);
  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_invalid_i && !in_valid_i) |=> !invalid_o);
endmodule

bind nan_prop_unit nan_prop_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .opa_i         (opa_i),
  .opb_i         (opb_i),
  .sig_inv_i     (sig_inv_i),
  .dflt_nan_i    (dflt_nan_i),
  .clr_invalid_i (clr_invalid_i),
  .res_valid_o   (res_valid_o),
  .res_o         (res_o),
  .invalid_o     (invalid_o)
);

// File: tb/nan_prop_unit_bench.sv
module nan_prop_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [1:0]  mode_i = '0;
  logic        sig_inv_i = 1'b0, dflt_nan_i = 1'b0, clr_invalid_i = 1'b0;
  logic        res_valid_o, invalid_o;
  logic [31:0] res_o;

  always #10 clk_i = ~clk_i;

  nan_prop_unit u_nan_prop_unit (.*);

  typedef struct {
    logic [31:0] res;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  logic exp_sticky = 1'b0;
  bit   done = 0;

  localparam logic [31:0] QA  = 32'h7FC1_2345;
  localparam logic [31:0] SA  = 32'h7F81_2345;
  localparam logic [31:0] QB  = 32'hFFC0_0001;
  localparam logic [31:0] SB  = 32'hFF80_0077;
  localparam logic [31:0] NUM = 32'h3F80_0000;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                       input logic inv, input logic dflt, input logic clr,
                       input logic [31:0] exp_r, input logic exp_set, input string tag);
    exp_t e;
    @(negedge clk_i);
    opa_i = a; opb_i = b; mode_i = m; sig_inv_i = inv; dflt_nan_i = dflt;
    clr_invalid_i = clr; in_valid_i = 1'b1;
    if (exp_set)  exp_sticky = 1'b1;
    else if (clr) exp_sticky = 1'b0;
    e.res = exp_r; e.inv = exp_sticky; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk_i);
    #1 in_valid_i = 1'b0; clr_invalid_i = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk_i);
    clr_invalid_i = 1'b1;
    @(negedge clk_i);
    clr_invalid_i = 1'b0;
    exp_sticky = 1'b0;
    check({31'd0, invalid_o}, 32'd0, "R12 clear");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && res_valid_o) begin
        if (exp_q.size() == 0) begin
          check(32'd1, 32'd0, "R10 unexpected res_valid_o");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res_o, e.res, e.tag);
          check({31'd0, invalid_o}, {31'd0, e.inv}, {e.tag, " invalid_o"});
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check({res_valid_o, invalid_o, 30'd0}, 32'd0, "R13 reset flags");
    check(res_o, 32'd0, "R13 reset result");
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);

    // mode 0, normal polarity
    drive(QA,  QB, 2'd0, 0, 0, 0, 32'h7FC1_2345, 0, "R1 R5 quiet A first");
    drive(NUM, QB, 2'd0, 0, 0, 0, 32'hFFC0_0001, 0, "R1 R5 lone quiet B");
    drive(QA,  SB, 2'd0, 0, 0, 0, 32'hFFC0_0077, 1, "R5 R3 signaling B");
    drive(SA,  SB, 2'd0, 0, 0, 0, 32'h7FC1_2345, 1, "R5 R3 signaling A");
    clear_flag();
    // mode 1
    drive(QA,  SB, 2'd1, 0, 0, 0, 32'h7FC1_2345, 1, "R6 quiet A over sig B");
    drive(NUM, SB, 2'd1, 0, 0, 0, 32'hFFC0_0077, 1, "R6 B when A not NaN");
    drive(SA,  QB, 2'd1, 0, 0, 0, 32'h7FC1_2345, 1, "R6 sig A");
    // mode 2
    drive(SA,  QB, 2'd2, 0, 0, 0, 32'hFFC0_0001, 1, "R7 quiet B over sig A");
    drive(QA,  SB, 2'd2, 0, 0, 0, 32'h7FC1_2345, 1, "R7 quiet A over sig B");
    drive(QA,  QB, 2'd2, 0, 0, 0, 32'h7FC1_2345, 0, "R7 two quiet A larger");
    drive(32'h7FC0_0001, 32'hFFC1_2345, 2'd2, 0, 0, 0, 32'hFFC1_2345, 0, "R7 two quiet B larger");
    drive(SA, 32'hFF8F_FFFF, 2'd2, 0, 0, 0, 32'hFFCF_FFFF, 1, "R7 two sig B larger");
    drive(SA,  NUM, 2'd2, 0, 0, 0, 32'h7FC1_2345, 1, "R7 lone sig A");
    drive(NUM, QB,  2'd2, 0, 0, 0, 32'hFFC0_0001, 0, "R7 lone quiet B");
    drive(32'h7FC0_0055, 32'hFFC0_0055, 2'd2, 0, 0, 0, 32'h7FC0_0055, 0, "R8 tie A positive");
    drive(32'hFFC0_0055, 32'h7FC0_0055, 2'd2, 0, 0, 0, 32'h7FC0_0055, 0, "R8 tie A negative");
    // mode 3
    drive(QA,  SB, 2'd3, 0, 0, 0, 32'hFFC0_0077, 1, "R9 reserved as mode 0");
    clear_flag();
    // inverted polarity
    drive(32'h7F81_2345, NUM, 2'd0, 1, 0, 0, 32'h7F81_2345, 0, "R2 inverted quiet passes");
    drive(32'h7F81_2345, 32'h7FC0_0001, 2'd0, 1, 0, 0, 32'h7FBF_FFFF, 1, "R2 R3 inverted sig B");
    drive(QA,  NUM, 2'd1, 1, 0, 0, 32'h7FBF_FFFF, 1, "R2 R3 inverted sig A");
    clear_flag();
    // default NaN mode
    drive(QA,  QB,  2'd0, 0, 1, 0, 32'h7FC0_0000, 0, "R4 default std");
    drive(SA,  QB,  2'd2, 0, 1, 0, 32'h7FC0_0000, 1, "R4 R11 default with sig");
    drive(32'h7F81_2345, NUM, 2'd1, 1, 1, 0, 32'h7FBF_FFFF, 0, "R4 default inverted");
    repeat (5) @(negedge clk_i);
    check({31'd0, invalid_o}, 32'd1, "R11 sticky hold");
    check({31'd0, res_valid_o}, 32'd0, "R10 idle valid low");
    check(res_o, 32'h7FBF_FFFF, "R10 result held");
    clear_flag();
    drive(SA,  NUM, 2'd0, 0, 0, 1, 32'h7FC1_2345, 1, "R12 set beats clear");
    repeat (3) @(negedge clk_i);
    check({31'd0, invalid_o}, 32'd1, "R12 set kept");
    check(exp_q.size(), 32'd0, "R10 all results seen");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule